// File: doc/BRIEF.md
# Sign-Extend and Byte-Order Unit

This is one execution slice of a 64-bit register machine. It takes one operation per cycle and does one of two things. The first is a move from a source operand, with optional sign extension from a narrower field. The second is a byte-order conversion of the destination value at a width of 16, 32 or 64 bits. An operand-class input picks the semantics: in the 32-bit class the upper word of the result is forced to zero, and in the 64-bit class the full register is written.

An upstream decoder presents the already-extracted fields: the operation, the class, the source-kind bit, the offset field, the immediate, the direction bit, the source operand and the current destination value. The unit registers its result. Its valid flag and illegal flag appear on the clock edge after the input strobe. An illegal combination does not alter the destination: the registered result equals the destination value that was presented. A parameter sets the host byte order, and the 32-bit class conversions depend on it.

Top module: `sxbo_unit`

## Requirements
- R1: Move (`in_op`=0) with `in_offset`=0 is a plain move. In the 64-bit class (`in_cls64`=1) the result is `in_src`. In the 32-bit class it is `in_src[31:0]` with bits 63:32 zero. It is never illegal.
- R2: In the 32-bit class, a move with a register source (`in_src_is_reg`=1) and `in_offset` of 8 or 16 sign-extends the low 8 or 16 bits to 32 bits and zeroes bits 63:32.
- R3: In the 64-bit class, a move with a register source and `in_offset` of 8, 16 or 32 sign-extends the low 8, 16 or 32 bits to the full 64 bits.
- R4: A move with a non-zero offset and an immediate source (`in_src_is_reg`=0) raises `out_illegal`, and the result equals `in_dst`.
- R5: A move with a register source raises `out_illegal` and yields `in_dst` when its non-zero offset is not a legal width for its class. Offset 32 is not legal in the 32-bit class, and any offset other than 8, 16 or 32 is not legal in either class.
- R6: Byte order (`in_op`=1) takes its width from `in_imm`. Values 16, 32 and 64 are legal. Any other value raises `out_illegal` and yields `in_dst`.
- R7: In the 64-bit class, byte order reverses the bytes of the low 16, 32 or 64 bits of `in_dst` whatever `in_to_big` is. At 16 and 32 bits, all bits above the width are zero.
- R8: In the 32-bit class, when the target order (`in_to_big`: 0 means little-endian, 1 means big-endian) differs from `HOST_BIG_ENDIAN`, the bytes at the selected width are reversed, with zero fill above.
- R9: In the 32-bit class, when the target order equals the host order, a width of 16 or 32 truncates `in_dst` to that width with zero fill above, and a width of 64 passes `in_dst` through unchanged.
- R10: `out_valid` equals `in_valid` delayed by exactly one clock. `out_result` and `out_illegal` describe the operation strobed on the previous edge. `out_illegal` is low whenever `out_valid` is low, and `out_result` holds its value through cycles with no strobe.
- R11: While `rst_n` is low at a clock edge, `out_valid`, `out_illegal` and `out_result` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 1 | 0 = move, 1 = byte-order conversion |
| in_cls64 | input | 1 | 1 = 64-bit class, 0 = 32-bit class |
| in_src_is_reg | input | 1 | 1 = source operand came from a register |
| in_offset | input | OFF_W (16) | Offset field; non-zero selects sign-extension width |
| in_src | input | XLEN (64) | Source operand |
| in_dst | input | XLEN (64) | Current destination value |
| in_imm | input | IMM_W (32) | Immediate; byte-order width |
| in_to_big | input | 1 | Byte-order target: 0 little-endian, 1 big-endian |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| out_result | output | XLEN (64) | Registered result |
| out_illegal | output | 1 | Registered illegal-combination flag |

## Verification
The illegal flag and the destination-preserving fallback must show up in the same result cycle. An illegal request must report the flag, and the result it writes in that same cycle must be the destination, not a partial computation. The bench forces this with immediate-source sign-extends, offsets outside the class's legal set and unsupported immediate widths. Each of these is paired with a destination pattern distinct from the source, and the flag and result are compared together in the single sample after the edge. Two instances, one per host order, take the same sweep. This checks that the class and direction choices between a swap and a truncation fall where the requirements say.

// File: rtl/sxbo_pkg.sv
// Package: shared operation encoding and width codes for the sign-extend
// and byte-order unit. Assumes a 64-bit register width throughout.
package sxbo_pkg;

    typedef enum logic {
        OP_MOVE  = 1'b0,
        OP_BSWAP = 1'b1
    } sxbo_op_e;

    // Index of a byte-order width inside the per-width result arrays.
    typedef enum logic [1:0] {
        BW_16  = 2'd0,
        BW_32  = 2'd1,
        BW_64  = 2'd2,
        BW_BAD = 2'd3
    } sxbo_bw_e;

    localparam int NUM_BW = 3;

endpackage

// File: rtl/sxbo_sign_ext.sv
// Module: sxbo_sign_ext
// Combinational move path. A zero offset gives a plain move. A non-zero offset
// selects the source width to sign-extend: 8/16 in the 32-bit class, and
// 8/16/32 in the 64-bit class. Any other request is flagged illegal.
// Assumes XLEN = 64 and an offset field at least 6 bits wide.
module sxbo_sign_ext #(
    parameter int XLEN  = 64,
    parameter int OFF_W = 16
) (
    input  logic             cls64,
    input  logic             src_is_reg,
    input  logic [OFF_W-1:0] offset,
    input  logic [XLEN-1:0]  src,
    output logic [XLEN-1:0]  result,
    output logic             illegal
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] sx8, sx16, sx32, picked;
    logic            width_ok;

    // Full-width sign extensions of each candidate field.
    always_comb begin
        sx8  = {{(XLEN-8){src[7]}},     src[7:0]};
        sx16 = {{(XLEN-16){src[15]}},   src[15:0]};
        sx32 = {{(XLEN-HALF){src[HALF-1]}}, src[HALF-1:0]};
    end

    // Decode the offset into a width choice and check it against the class.
    always_comb begin
        width_ok = 1'b1;
        picked   = src;
        case (offset)
            OFF_W'(0):  picked = src;
            OFF_W'(8):  picked = sx8;
            OFF_W'(16): picked = sx16;
            OFF_W'(32): begin
                picked   = sx32;
                width_ok = cls64;
            end
            default:    width_ok = 1'b0;
        endcase
    end

    // Apply the class's upper-word rule and the source-kind restriction.
    always_comb begin
        illegal = (offset != '0) && (!src_is_reg || !width_ok);
        result  = cls64 ? picked : {{(XLEN-HALF){1'b0}}, picked[HALF-1:0]};
    end

endmodule

// File: rtl/sxbo_byte_order.sv
// Module: sxbo_byte_order
// Combinational byte-order path. It builds a byte-reversed and a truncated copy
// of the destination at 16, 32 and 64 bits, then picks one. The 64-bit class
// always reverses. The 32-bit class reverses only when the target order differs
// from the host order. Assumes XLEN = 64.
module sxbo_byte_order
    import sxbo_pkg::*;
#(
    parameter int XLEN            = 64,
    parameter int IMM_W           = 32,
    parameter bit HOST_BIG_ENDIAN = 1'b0
) (
    input  logic             cls64,
    input  logic             to_big,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  dst,
    output logic [XLEN-1:0]  result,
    output logic             illegal
);
    localparam int NB = XLEN / 8;

    logic [XLEN-1:0] rev_w   [NUM_BW];
    logic [XLEN-1:0] trunc_w [NUM_BW];
    sxbo_bw_e        bw;
    logic            do_swap;

    // Per-width reversal and truncation networks.
    for (genvar w = 0; w < NUM_BW; w++) begin : g_width
        localparam int NBW = 2 << w;
        for (genvar b = 0; b < NBW; b++) begin : g_byte
            assign rev_w[w][8*b +: 8] = dst[8*(NBW-1-b) +: 8];
        end
        if (NBW < NB) begin : g_fill
            assign rev_w[w][XLEN-1:8*NBW]   = '0;
            assign trunc_w[w]               = {{(XLEN-8*NBW){1'b0}}, dst[8*NBW-1:0]};
        end else begin : g_full
            assign trunc_w[w] = dst;
        end
    end

    // Decode the immediate into a width index.
    always_comb begin
        case (imm)
            IMM_W'(16): bw = BW_16;
            IMM_W'(32): bw = BW_32;
            IMM_W'(64): bw = BW_64;
            default:    bw = BW_BAD;
        endcase
    end

    // Pick swap or truncation; an illegal width leaves the destination as is.
    always_comb begin
        do_swap = cls64 || (to_big != HOST_BIG_ENDIAN);
        illegal = (bw == BW_BAD);
        if (illegal)
            result = dst;
        else if (do_swap)
            result = rev_w[bw];
        else
            result = trunc_w[bw];
    end

endmodule

// File: rtl/sxbo_unit.sv
// Module: sxbo_unit (top)
// Execution slice for sign-extending moves and byte-order conversion. It picks
// one of the two combinational paths, substitutes the destination value on an
// illegal request, and registers the result with a one-clock valid flag.
// Assumes XLEN = 64. Reset is synchronous and active low.
module sxbo_unit
    import sxbo_pkg::*;
#(
    parameter int XLEN            = 64,
    parameter int OFF_W           = 16,
    parameter int IMM_W           = 32,
    parameter bit HOST_BIG_ENDIAN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_op,
    input  logic             in_cls64,
    input  logic             in_src_is_reg,
    input  logic [OFF_W-1:0] in_offset,
    input  logic [XLEN-1:0]  in_src,
    input  logic [XLEN-1:0]  in_dst,
    input  logic [IMM_W-1:0] in_imm,
    input  logic             in_to_big,
    output logic             out_valid,
    output logic [XLEN-1:0]  out_result,
    output logic             out_illegal
);
    logic [XLEN-1:0] mv_result, bo_result, next_result;
    logic            mv_illegal, bo_illegal, next_illegal;

    sxbo_sign_ext #(.XLEN(XLEN), .OFF_W(OFF_W)) u_sign_ext (
        .cls64      (in_cls64),
        .src_is_reg (in_src_is_reg),
        .offset     (in_offset),
        .src        (in_src),
        .result     (mv_result),
        .illegal    (mv_illegal)
    );

    sxbo_byte_order #(.XLEN(XLEN), .IMM_W(IMM_W), .HOST_BIG_ENDIAN(HOST_BIG_ENDIAN)) u_byte_order (
        .cls64   (in_cls64),
        .to_big  (in_to_big),
        .imm     (in_imm),
        .dst     (in_dst),
        .result  (bo_result),
        .illegal (bo_illegal)
    );

    // Select the active path and fall back to the destination when illegal.
    always_comb begin
        next_illegal = (in_op == OP_BSWAP) ? bo_illegal : mv_illegal;
        if (next_illegal)
            next_result = in_dst;
        else
            next_result = (in_op == OP_BSWAP) ? bo_result : mv_result;
    end

    // Output register: valid follows the strobe, result loads only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_result  <= '0;
        end else begin
            out_valid   <= in_valid;
            out_illegal <= in_valid && next_illegal;
            if (in_valid)
                out_result <= next_result;
        end
    end

    // R10: the valid flag rises one clock after a strobe.
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10: no strobe means no valid and no illegal report on the next clock.
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_illegal));

    // R4: a sign-extend with an immediate source is flagged and keeps the destination.
    a_r4_imm_source_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_MOVE && in_offset != '0 && !in_src_is_reg)
        |=> (out_illegal && out_result == $past(in_dst)));

    // R6: an unsupported byte-order width is flagged and keeps the destination.
    a_r6_bad_width_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_BSWAP && in_imm != IMM_W'(16) &&
         in_imm != IMM_W'(32) && in_imm != IMM_W'(64))
        |=> (out_illegal && out_result == $past(in_dst)));

    // R1/R2: a legal 32-bit class move leaves the upper word zero.
    a_r2_upper_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_MOVE && !in_cls64)
        |=> (out_illegal || out_result[XLEN-1:XLEN/2] == '0));

    // R7: a legal 16-bit byte-order result has nothing above bit 15.
    a_r7_width16_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_BSWAP && in_imm == IMM_W'(16))
        |=> (out_result[XLEN-1:16] == '0));

endmodule

// File: tb/sxbo_unit_bench.sv
module sxbo_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_op = 1'b0;
    logic        in_cls64 = 1'b0;
    logic        in_src_is_reg = 1'b0;
    logic [15:0] in_offset = '0;
    logic [63:0] in_src = '0;
    logic [63:0] in_dst = '0;
    logic [31:0] in_imm = '0;
    logic        in_to_big = 1'b0;
    logic        le_valid, le_illegal, be_valid, be_illegal;
    logic [63:0] le_result, be_result;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sxbo_unit #(.HOST_BIG_ENDIAN(1'b0)) u_sxbo_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_cls64(in_cls64), .in_src_is_reg(in_src_is_reg), .in_offset(in_offset),
        .in_src(in_src), .in_dst(in_dst), .in_imm(in_imm), .in_to_big(in_to_big),
        .out_valid(le_valid), .out_result(le_result), .out_illegal(le_illegal));

    sxbo_unit #(.HOST_BIG_ENDIAN(1'b1)) u_sxbo_unit_be (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_cls64(in_cls64), .in_src_is_reg(in_src_is_reg), .in_offset(in_offset),
        .in_src(in_src), .in_dst(in_dst), .in_imm(in_imm), .in_to_big(in_to_big),
        .out_valid(be_valid), .out_result(be_result), .out_illegal(be_illegal));

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] byte_rev(input logic [63:0] v, input int nb);
        logic [63:0] r = '0;
        for (int b = 0; b < nb; b++)
            r[8*b +: 8] = v[8*(nb-1-b) +: 8];
        return r;
    endfunction

    // Reference model built from the requirement text.
    task automatic model(input bit host_be, output logic [63:0] res,
                         output bit ill, output string tag);
        int w;
        logic signed [63:0] t;
        ill = 0;
        if (in_op == 1'b0) begin
            w = int'(in_offset);
            if (w == 0) begin
                tag = "R1";
                res = in_cls64 ? in_src : (in_src & 64'h0000_0000_FFFF_FFFF);
            end else if (!in_src_is_reg) begin
                tag = "R4"; ill = 1; res = in_dst;
            end else if (!(w == 8 || w == 16 || (w == 32 && in_cls64))) begin
                tag = "R5"; ill = 1; res = in_dst;
            end else begin
                t = $signed(in_src << (64 - w)) >>> (64 - w);
                if (in_cls64) begin tag = "R3"; res = t; end
                else begin tag = "R2"; res = t & 64'h0000_0000_FFFF_FFFF; end
            end
        end else begin
            w = int'(in_imm);
            if (!(w == 16 || w == 32 || w == 64)) begin
                tag = "R6"; ill = 1; res = in_dst;
            end else if (in_cls64 || (in_to_big != host_be)) begin
                tag = in_cls64 ? "R7" : "R8";
                res = byte_rev(in_dst, w / 8);
            end else begin
                tag = "R9";
                res = (w == 64) ? in_dst : (in_dst & ((64'd1 << w) - 64'd1));
            end
        end
    endtask

    // Apply one operation, sample both instances after the edge, then check the idle hold.
    task automatic run_op;
        logic [63:0] le_exp, be_exp;
        bit le_ill, be_ill;
        string le_tag, be_tag;
        model(1'b0, le_exp, le_ill, le_tag);
        model(1'b1, be_exp, be_ill, be_tag);
        in_valid = 1'b1;
        @(negedge clk);
        check({le_tag, " result (LE host)"}, le_result, le_exp);
        check({le_tag, " illegal (LE host)"}, {63'd0, le_illegal}, {63'd0, le_ill});
        check({be_tag, " result (BE host)"}, be_result, be_exp);
        check({be_tag, " illegal (BE host)"}, {63'd0, be_illegal}, {63'd0, be_ill});
        check("R10 valid one clock after strobe", {63'd0, le_valid}, 64'd1);
        in_valid = 1'b0;
        in_dst = ~in_dst;
        @(negedge clk);
        check("R10 valid low without strobe", {63'd0, le_valid}, 64'd0);
        check("R10 illegal low without strobe", {63'd0, le_illegal}, 64'd0);
        check("R10 result held without strobe", le_result, le_exp);
    endtask

    initial begin
        logic [63:0] pats [4];
        int offs [6];
        int imms [6];
        pats[0] = 64'h0123_4567_89AB_CDEF;
        pats[1] = 64'hFEDC_BA98_7654_3210;
        pats[2] = 64'h8000_0000_8000_8080;
        pats[3] = 64'h7FFF_FFFF_7FFF_7F7F;
        offs[0] = 0;  offs[1] = 8;  offs[2] = 16; offs[3] = 32; offs[4] = 1;  offs[5] = 64;
        imms[0] = 16; imms[1] = 32; imms[2] = 64; imms[3] = 0;  imms[4] = 8;  imms[5] = 48;

        repeat (3) @(negedge clk);
        check("R11 valid in reset", {63'd0, le_valid}, 64'd0);
        check("R11 illegal in reset", {63'd0, le_illegal}, 64'd0);
        check("R11 result in reset", le_result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 2; c++) begin
                in_cls64 = c[0];
                in_op = 1'b0;
                for (int o = 0; o < 6; o++) begin
                    for (int r = 0; r < 2; r++) begin
                        in_offset = 16'(offs[o]);
                        in_src_is_reg = r[0];
                        in_src = pats[p];
                        in_dst = pats[(p + 1) % 4] ^ 64'h5A5A_0000_0000_A5A5;
                        run_op();
                    end
                end
                in_op = 1'b1;
                for (int d = 0; d < 2; d++) begin
                    for (int i = 0; i < 6; i++) begin
                        in_to_big = d[0];
                        in_imm = 32'(imms[i]);
                        in_src = pats[(p + 2) % 4];
                        in_dst = pats[p];
                        run_op();
                    end
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule